// File: doc/BRIEF.md
# Presettable Synchronous Down Counter

This block is an eight-stage down counter built from two four-bit digit cells. A mode parameter selects the counting base: a plain 8-bit binary counter, or a pair of packed BCD decades running from 99 down to 00. A counter of this kind serves as a programmable divider or interval timer. The caller loads a start value, lets the counter run down, and reacts to the zero flag.

Every control input and the zero flag are active-low. Two controls act without waiting for the clock. The clear control forces the maximum count, which is 255 in binary mode and 0x99 in decade mode. The asynchronous preset forces the jam word. A third control loads the jam word on the next rising edge even while counting is disabled. The zero flag is decoded combinationally from the registered count and the count enable. Because of this, the flag of one counter can drive the active-low enable of the next counter on the same clock within the same cycle.

The pins are plain level controls with no valid/ready handshake. The block neither produces nor accepts a data stream, so back-pressure does not apply.

Top module: `dcnt_presettable`

## Requirements
- R1: While `clr_n` is low, `count` equals the maximum count without waiting for a clock edge: 8'hFF in binary mode, 8'h99 in decade mode. This holds whatever the levels of `apre_n`, `spre_n` and `cen_n`.
- R2: When `apre_n` goes low with `clr_n` high, `count` takes the value of `jam` at once, with no clock edge. While `apre_n` stays low, clock edges, `spre_n` and `cen_n` have no effect.
- R3: When `spre_n` is low at a rising edge, with `clr_n` and `apre_n` high, `count` takes the value of `jam` at that edge, whatever the level of `cen_n`. A low `spre_n` alone does not change `count` between edges.
- R4: When all four controls are high, `count` keeps its value across clock edges, even if `jam` changes.
- R5: When `cen_n` is low and the other three controls are high, `count` decreases by one at each rising edge.
- R6: A decrement from zero wraps to the maximum count. A free-running cycle is 256 edges in binary mode and 100 edges in decade mode.
- R7: `zero_n` is low exactly when `count` is zero and `cen_n` is low. The flag follows `cen_n` combinationally, without a clock edge.
- R8: In decade mode, `count[7:4]` is the tens digit and `count[3:0]` is the units digit, each in BCD with its MSB at the top; `jam` uses the same layout. When the units digit wraps from 0 to 9, the tens digit decrements on the same edge, so 0x40 becomes 0x39.
- R9: In decade mode, a digit code above 9 loaded from `jam` decrements by one in binary. It then rejoins the 9-to-0 sequence. For example, 0xAC becomes 0xAB and 0xA0 becomes 0x99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear to the maximum count, active-low, highest precedence |
| apre_n | input | 1 | Asynchronous load of `jam`, active-low |
| spre_n | input | 1 | Synchronous load of `jam` on the next rising edge, active-low |
| cen_n | input | 1 | Count enable and carry-in, active-low |
| jam | input | 8 | Preset word, binary or two packed BCD digits |
| count | output | 8 | Registered count value |
| zero_n | output | 1 | Zero detect and carry-out, active-low |

## Verification
Two situations are hard to reach from the ports: decade digits above 9, and the full 100- and 256-edge wrap. A normal run never produces illegal decade digits, so the bench places them directly with synchronous jam loads (0xA0, 0xAC) and checks a single decrement from each. The full wrap is reached by loading zero and letting one binary and one decade instance run 100 and then 156 edges from shared inputs. The expected values are 0x9C/0x00 and 0x00/0x44. The asynchronous paths are checked a fraction of a nanosecond after the control changes, well before the next edge. This separates them from any clocked effect.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic {
    CNT_MODE_BINARY = 1'b0,
    CNT_MODE_DECADE = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/dcnt_digit.sv
// One digit cell: decrements when 'take' is high, wraps to WRAP from zero and
// raises 'borrow' so the next digit up decrements on the same edge.
module dcnt_digit #(
  parameter int unsigned     W    = 4,
  parameter logic [W-1:0]    WRAP = '1
) (
  input  logic [W-1:0] d,
  input  logic         take,
  output logic [W-1:0] d_next,
  output logic         borrow
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic at_zero;
  assign at_zero = (d == '0);

  always_comb begin
    borrow = take && at_zero;
    if (!take)       d_next = d;
    else if (at_zero) d_next = WRAP;
    else             d_next = d - ONE;   // codes above WRAP fall back by one
  end
endmodule

// File: rtl/dcnt_next.sv
// Borrow chain of digit cells giving the decremented count.
module dcnt_next #(
  parameter int unsigned         DIGIT_W = 4,
  parameter int unsigned         DIGITS  = 2,
  parameter logic [DIGIT_W-1:0]  WRAP    = '1,
  localparam int unsigned        CNT_W   = DIGIT_W * DIGITS
) (
  input  logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] nxt,
  output logic             wrap_all
);
  logic [DIGITS:0] chain;
  assign chain[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    dcnt_digit #(.W(DIGIT_W), .WRAP(WRAP)) u_digit (
      .d      (cur[i*DIGIT_W +: DIGIT_W]),
      .take   (chain[i]),
      .d_next (nxt[i*DIGIT_W +: DIGIT_W]),
      .borrow (chain[i+1])
    );
  end

  assign wrap_all = chain[DIGITS];
endmodule

// File: rtl/dcnt_zero_flag.sv
// Active-low zero detect, qualified by the active-low carry-in.
module dcnt_zero_flag #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             cen_n,
  output logic             zero_n
);
  assign zero_n = ~((cnt == '0) & ~cen_n);
endmodule

// File: rtl/dcnt_presettable.sv
module dcnt_presettable
  import dcnt_pkg::*;
#(
  parameter cnt_mode_e   MODE    = CNT_MODE_BINARY,
  parameter int unsigned DIGIT_W = 4,
  parameter int unsigned DIGITS  = 2,
  localparam int unsigned CNT_W  = DIGIT_W * DIGITS
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             apre_n,
  input  logic             spre_n,
  input  logic             cen_n,
  input  logic [CNT_W-1:0] jam,
  output logic [CNT_W-1:0] count,
  output logic             zero_n
);
  localparam logic [DIGIT_W-1:0] WRAP =
    (MODE == CNT_MODE_DECADE) ? DIGIT_W'(9) : {DIGIT_W{1'b1}};
  localparam logic [CNT_W-1:0]   MAX_CNT = {DIGITS{WRAP}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap_all;

  dcnt_next #(.DIGIT_W(DIGIT_W), .DIGITS(DIGITS), .WRAP(WRAP)) u_next (
    .cur      (cnt_q),
    .nxt      (cnt_nxt),
    .wrap_all (wrap_all)
  );

  // Precedence: clear, asynchronous jam, synchronous jam, count enable.
  always_ff @(posedge clk or negedge clr_n or negedge apre_n) begin
    if (!clr_n)       cnt_q <= MAX_CNT;
    else if (!apre_n) cnt_q <= jam;
    else if (!spre_n) cnt_q <= jam;
    else if (!cen_n)  cnt_q <= cnt_nxt;
  end

  dcnt_zero_flag #(.CNT_W(CNT_W)) u_zero (
    .cnt    (cnt_q),
    .cen_n  (cen_n),
    .zero_n (zero_n)
  );

  assign count = cnt_q;

  logic quiet_async;
  assign quiet_async = clr_n && apre_n;

  // R1: a held clear leaves the maximum count at every edge
  a_r1_clear_max: assert property (@(posedge clk) disable iff (!apre_n)
    !clr_n |-> cnt_q == MAX_CNT);

  // R3: synchronous jam load wins over the count enable
  a_r3_sync_load: assert property (@(posedge clk) disable iff (!quiet_async)
    (quiet_async && !spre_n) |=> cnt_q == $past(jam));

  // R4: no active control, no change
  a_r4_hold: assert property (@(posedge clk) disable iff (!quiet_async)
    (quiet_async && spre_n && cen_n) |=> $stable(cnt_q));

  // R6: a full borrow out of the top digit lands on the maximum count
  a_r6_wrap_max: assert property (@(posedge clk) disable iff (!quiet_async)
    (quiet_async && spre_n && !cen_n && wrap_all) |=> cnt_q == MAX_CNT);

  // R7: an asserted zero flag while counting means the next edge wraps
  a_r7_zero_then_max: assert property (@(posedge clk) disable iff (!quiet_async)
    (quiet_async && spre_n && !zero_n) |=> cnt_q == MAX_CNT);

  if (MODE == CNT_MODE_BINARY) begin : g_bin_chk
    // R5: binary decrement by exactly one, modulo the width
    a_r5_dec_one: assert property (@(posedge clk) disable iff (!quiet_async)
      (quiet_async && spre_n && !cen_n) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  end
endmodule

// File: tb/tb_dcnt_presettable.sv
`timescale 1ns/1ps
module tb_dcnt_presettable;
  import dcnt_pkg::*;

  logic       clk = 1'b0;
  logic       clr_n = 1'b1, apre_n = 1'b1, spre_n = 1'b1, cen_n = 1'b1;
  logic [7:0] jam = 8'h00;
  logic [7:0] cnt_b, cnt_d;
  logic       zn_b, zn_d;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  dcnt_presettable #(.MODE(CNT_MODE_BINARY)) dut (
    .clk(clk), .clr_n(clr_n), .apre_n(apre_n), .spre_n(spre_n), .cen_n(cen_n),
    .jam(jam), .count(cnt_b), .zero_n(zn_b));

  dcnt_presettable #(.MODE(CNT_MODE_DECADE)) dut_dec (
    .clk(clk), .clr_n(clr_n), .apre_n(apre_n), .spre_n(spre_n), .cen_n(cen_n),
    .jam(jam), .count(cnt_d), .zero_n(zn_d));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); jam = v; spre_n = 1'b0; cen_n = 1'b1;
    @(negedge clk); spre_n = 1'b1;
  endtask

  task automatic run(input int n);
    cen_n = 1'b0;
    repeat (n) @(negedge clk);
    cen_n = 1'b1;
  endtask

  task automatic t_reset;
    #1 clr_n = 1'b0;
    #2;
    chk("R1 reset bin", cnt_b, 8'hFF);
    chk("R1 reset dec", cnt_d, 8'h99);
    @(negedge clk); clr_n = 1'b1;
  endtask

  task automatic t_async_preset;
    @(negedge clk); jam = 8'h37; spre_n = 1'b0; cen_n = 1'b0; apre_n = 1'b0;
    #1;
    chk("R2 async bin", cnt_b, 8'h37);
    chk("R2 async dec", cnt_d, 8'h37);
    @(negedge clk);
    chk("R2 held over edge", cnt_b, 8'h37);
    apre_n = 1'b1; spre_n = 1'b1; cen_n = 1'b1;
  endtask

  task automatic t_sync_load;
    @(negedge clk); jam = 8'h52; spre_n = 1'b0; cen_n = 1'b1;
    #1 chk("R3 no effect before edge", cnt_b, 8'h37);
    @(negedge clk);
    chk("R3 sync load", cnt_b, 8'h52);
    jam = 8'h10; cen_n = 1'b0;
    @(negedge clk);
    chk("R3 load beats enable bin", cnt_b, 8'h10);
    chk("R3 load beats enable dec", cnt_d, 8'h10);
    spre_n = 1'b1; cen_n = 1'b1;
  endtask

  task automatic t_hold;
    load(8'h66);
    jam = 8'h11;
    repeat (3) @(negedge clk);
    chk("R4 hold bin", cnt_b, 8'h66);
    chk("R4 hold dec", cnt_d, 8'h66);
  endtask

  task automatic t_count_zero;
    load(8'h05);
    run(3);
    chk("R5 dec bin", cnt_b, 8'h02);
    chk("R5 dec dec", cnt_d, 8'h02);
    cen_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 reach zero", cnt_b, 8'h00);
    chk("R7 zero flag low bin", {7'd0, zn_b}, 8'h00);
    chk("R7 zero flag low dec", {7'd0, zn_d}, 8'h00);
    cen_n = 1'b1;
    #1 chk("R7 flag follows enable", {7'd0, zn_b}, 8'h01);
    cen_n = 1'b0;
    #1 chk("R7 flag returns low", {7'd0, zn_b}, 8'h00);
    @(negedge clk);
    chk("R6 wrap bin", cnt_b, 8'hFF);
    chk("R6 wrap dec", cnt_d, 8'h99);
    chk("R7 flag high off zero", {7'd0, zn_d}, 8'h01);
    cen_n = 1'b1;
  endtask

  task automatic t_full_cycle;
    load(8'h00);
    run(100);
    chk("R6 100 edges bin", cnt_b, 8'h9C);
    chk("R6 100 edges dec", cnt_d, 8'h00);
    run(156);
    chk("R6 256 edges bin", cnt_b, 8'h00);
    chk("R6 256 edges dec", cnt_d, 8'h44);
  endtask

  task automatic t_decade_borrow;
    load(8'h40); run(1);
    chk("R8 borrow dec", cnt_d, 8'h39);
    chk("R5 same step bin", cnt_b, 8'h3F);
    load(8'h10); run(1);
    chk("R8 tens to zero", cnt_d, 8'h09);
  endtask

  task automatic t_illegal_digit;
    load(8'hAC); run(1);
    chk("R9 units above nine", cnt_d, 8'hAB);
    load(8'hA0); run(1);
    chk("R9 tens above nine", cnt_d, 8'h99);
    chk("R5 same step bin", cnt_b, 8'h9F);
  endtask

  task automatic t_clear_override;
    load(8'h23);
    @(negedge clk); jam = 8'h44; clr_n = 1'b0; apre_n = 1'b0; spre_n = 1'b0; cen_n = 1'b0;
    #1;
    chk("R1 clear wins bin", cnt_b, 8'hFF);
    chk("R1 clear wins dec", cnt_d, 8'h99);
    @(negedge clk);
    chk("R1 clear held", cnt_d, 8'h99);
    apre_n = 1'b1; spre_n = 1'b1; cen_n = 1'b1;
    @(negedge clk); clr_n = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_async_preset();
    t_sync_load();
    t_hold();
    t_count_zero();
    t_full_cycle();
    t_decade_borrow();
    t_illegal_digit();
    t_clear_override();
    finish_run();
  end
endmodule